// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a virtual page number into a leaf page table entry when the translation buffer misses. It walks a four-level radix tree of 64-bit entries, taking 9 bits of the virtual page number per level, and makes one entry read per level through a single request/response memory port. The walk starts from a root table frame supplied on an input. Each following level's table frame comes from the frame field of the entry just read.

Each entry's present bit is tested before the walk goes any deeper. The first clear present bit ends the walk at once with a fault that reports the level where it stopped. When the leaf is present, the walker sets the accessed bit, and on a write access also the dirty bit. It writes the entry back with one memory write, and only when one of those bits actually changes. It then pulses a done strobe carrying the final leaf entry, which is the data used to refill the translation buffer. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and after reset, `busy`, `walk_done`, `walk_fault` and `mem_req_valid` are low until a request is accepted.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is then high up to and including the cycle of the `walk_done` or `walk_fault` pulse, and low the cycle after it.
- R3: The entry read at a level has address {table frame, index, 3'b000}. The index is `req_vpn` bits 35:27, 26:18, 17:9 and 8:0 for levels 3, 2, 1 and 0, with level 3 the top. The first table frame is `root_frame`. Each later table frame is bits 51:12 of the entry read at the level above.
- R4: An entry's bit 0 is its present bit. When a read returns an entry with bit 0 clear, the walk ends with a one-cycle `walk_fault` pulse, with `fault_level` set to that level (3 top to 0 leaf) and `result_pte` set to the entry as read. No further memory request is issued, and no other bit of that entry has any effect.
- R5: For a present leaf, the updated entry is the leaf with bit 5 (accessed) set, and also bit 6 (dirty) set when `req_write` was high. The updated entry is written to the leaf's own address with exactly one write.
- R6: When the updated leaf equals the leaf as read, no write is issued.
- R7: A present leaf ends the walk with a one-cycle `walk_done` pulse, with `result_pte` equal to the updated leaf. `walk_done` and `walk_fault` are never high together.
- R8: A memory request that is not accepted keeps its valid, write flag, address and data stable until `mem_req_ready` is high. No request is issued while a read response is pending.
- R9: A walk issues at most four reads: 1, 2, 3 or 4 for a fault at level 3, 2, 1 or 0, and 4 for a walk that reaches a present leaf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_vpn | input | 36 | Virtual page number to resolve |
| req_write | input | 1 | Access that missed is a write |
| root_frame | input | 40 | Frame number of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write (1) or a read (0) |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry data for a write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by a read |
| walk_done | output | 1 | Walk completed with a present leaf |
| walk_fault | output | 1 | Walk stopped on a clear present bit |
| fault_level | output | 2 | Level at which the walk stopped |
| result_pte | output | 64 | Final leaf entry, or the faulting entry |

## Verification
The assertions check on every cycle that a stalled memory request stays stable and that no request overlaps a pending read. They also check that a read returning a clear present bit is followed at once by a fault pulse with the port idle, that every write-back carries the accessed bit, that no walk exceeds four reads, and that busy frames each completion pulse. Only the bench scenarios show that the right address is formed at each level from the index fields and the chained frames, and that the fault level and read count match where the walk stopped. They also show that junk in a non-present entry changes nothing, and whether a write-back happens and with which value across read and write accesses on leaves whose accessed and dirty bits start clear or set.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // Entry bit positions used by the walker
  localparam int PTE_PRESENT  = 0;
  localparam int PTE_ACCESSED = 5;
  localparam int PTE_DIRTY    = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

endpackage

// File: rtl/pt_entry_addr.sv
// Forms the byte address of the entry to read at the current level.
module pt_entry_addr #(
  parameter int LEVELS  = 4,
  parameter int IDX_W   = 9,
  parameter int LVL_W   = 2,
  parameter int VPN_W   = 36,
  parameter int FRAME_W = 40,
  parameter int PA_W    = 52
) (
  input  logic [VPN_W-1:0]   vpn,
  input  logic [LVL_W-1:0]   level,
  input  logic [FRAME_W-1:0] frame,
  output logic [PA_W-1:0]    addr
);

  localparam int OFS_W = PA_W - FRAME_W - IDX_W;

  logic [IDX_W-1:0] idx_by_level [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_level[g] = vpn[IDX_W*g +: IDX_W];
  end

  assign addr = {frame, idx_by_level[level], {OFS_W{1'b0}}};

endmodule

// File: rtl/pt_leaf_update.sv
// Computes the leaf entry with accessed (and on writes dirty) set.
module pt_leaf_update
  import pt_walk_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_in,
  input  logic             write_access,
  output logic [PTE_W-1:0] pte_out,
  output logic             changed
);

  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[PTE_ACCESSED] = 1'b1;
    set_mask[PTE_DIRTY]    = write_access;
  end

  assign pte_out = pte_in | set_mask;
  assign changed = (pte_out != pte_in);

endmodule

// File: rtl/pt_walk_ctrl.sv
// Walk sequencer: level counter, table frame, captured entry.
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter int LEVELS     = 4,
  parameter int VPN_W      = 36,
  parameter int FRAME_W    = 40,
  parameter int PTE_W      = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int LVL_W      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_write,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  input  logic [PTE_W-1:0]   leaf_pte,
  input  logic               leaf_changed,
  output walk_state_t        state,
  output logic [LVL_W-1:0]   level,
  output logic [FRAME_W-1:0] table_frame,
  output logic [VPN_W-1:0]   vpn,
  output logic               is_write,
  output logic [PTE_W-1:0]   entry
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  walk_state_t        st_q, st_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic [VPN_W-1:0]   vpn_q, vpn_d;
  logic               wr_q, wr_d;
  logic [PTE_W-1:0]   pte_q, pte_d;
  logic               ld_en;

  assign ld_en = ((st_q == ST_IDLE) && req_valid) ||
                 ((st_q == ST_RD_WAIT) && mem_rsp_valid);

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    frm_d = frm_q;
    vpn_d = vpn_q;
    wr_d  = wr_q;
    pte_d = pte_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d  = ST_RD_REQ;
          lvl_d = TOP_LVL;
          frm_d = root_frame;
          vpn_d = req_vpn;
          wr_d  = req_write;
        end
      end
      ST_RD_REQ: begin
        if (mem_req_ready) st_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          pte_d = mem_rsp_data;
          if (!mem_rsp_data[PTE_PRESENT]) begin
            st_d = ST_FAULT;
          end else if (lvl_q != '0) begin
            lvl_d = lvl_q - 1'b1;
            frm_d = mem_rsp_data[PAGE_SHIFT +: FRAME_W];
            st_d  = ST_RD_REQ;
          end else if (leaf_changed) begin
            pte_d = leaf_pte;
            st_d  = ST_WR_REQ;
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      ST_WR_REQ: begin
        if (mem_req_ready) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lvl_q <= '0;
      frm_q <= '0;
      vpn_q <= '0;
      wr_q  <= 1'b0;
      pte_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_en) begin
        lvl_q <= lvl_d;
        frm_q <= frm_d;
        vpn_q <= vpn_d;
        wr_q  <= wr_d;
        pte_q <= pte_d;
      end
    end
  end

  assign state       = st_q;
  assign level       = lvl_q;
  assign table_frame = frm_q;
  assign vpn         = vpn_q;
  assign is_write    = wr_q;
  assign entry       = pte_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int PTE_W  = 64,
  parameter int PA_W   = 52,
  localparam int PAGE_SHIFT = IDX_W + $clog2(PTE_W / 8),
  localparam int VPN_W      = IDX_W * LEVELS,
  localparam int FRAME_W    = PA_W - PAGE_SHIFT,
  localparam int LVL_W      = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_write,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [PTE_W-1:0]   mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               walk_done,
  output logic               walk_fault,
  output logic [LVL_W-1:0]   fault_level,
  output logic [PTE_W-1:0]   result_pte
);

  // Reset asserts asynchronously, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  walk_state_t        state;
  logic [LVL_W-1:0]   level;
  logic [FRAME_W-1:0] table_frame;
  logic [VPN_W-1:0]   vpn;
  logic               is_write;
  logic [PTE_W-1:0]   entry;
  logic [PTE_W-1:0]   leaf_pte;
  logic               leaf_changed;

  pt_leaf_update #(.PTE_W(PTE_W)) u_leaf (
    .pte_in       (mem_rsp_data),
    .write_access (is_write),
    .pte_out      (leaf_pte),
    .changed      (leaf_changed)
  );

  pt_walk_ctrl #(
    .LEVELS(LEVELS), .VPN_W(VPN_W), .FRAME_W(FRAME_W),
    .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_vpn       (req_vpn),
    .req_write     (req_write),
    .root_frame    (root_frame),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .leaf_pte      (leaf_pte),
    .leaf_changed  (leaf_changed),
    .state         (state),
    .level         (level),
    .table_frame   (table_frame),
    .vpn           (vpn),
    .is_write      (is_write),
    .entry         (entry)
  );

  pt_entry_addr #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W),
    .VPN_W(VPN_W), .FRAME_W(FRAME_W), .PA_W(PA_W)
  ) u_addr (
    .vpn   (vpn),
    .level (level),
    .frame (table_frame),
    .addr  (mem_req_addr)
  );

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_write = (state == ST_WR_REQ);
  assign mem_req_wdata = entry;
  assign walk_done     = (state == ST_DONE);
  assign walk_fault    = (state == ST_FAULT);
  assign fault_level   = level;
  assign result_pte    = entry;

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int LEVELS = 4,
  parameter int PTE_W  = 64,
  parameter int PA_W   = 52
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [PTE_W-1:0] mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic [PTE_W-1:0] mem_rsp_data,
  input logic             walk_done,
  input logic             walk_fault
);

  logic       rd_out;
  logic [3:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_out <= 1'b0;
      rd_cnt <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out <= 1'b1;
      else if (mem_rsp_valid)                               rd_out <= 1'b0;
      if (req_valid && !busy)
        rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready && !mem_req_write)
        rd_cnt <= rd_cnt + 1'b1;
    end
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !mem_req_valid);

  a_r4_stop_on_absent: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out && mem_rsp_valid && !mem_rsp_data[0] |=> walk_fault && !mem_req_valid);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault));

  a_r5_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[5] && mem_req_wdata[0]);

  a_r9_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 4'(LEVELS));

  a_r2_busy_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done || walk_fault |-> busy);

  a_r2_idle_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done || walk_fault |=> !busy);

endmodule

bind pt_walker pt_walker_checker #(.LEVELS(LEVELS), .PTE_W(PTE_W), .PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .walk_done     (walk_done),
  .walk_fault    (walk_fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [35:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic [39:0] root_frame = 40'd1;
  logic        busy, mem_req_valid, mem_req_ready, mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        walk_done, walk_fault;
  logic [1:0]  fault_level;
  logic [63:0] result_pte;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_write(req_write), .root_frame(root_frame), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_level(fault_level), .result_pte(result_pte)
  );

  // Memory model: frames 0..7, entry index = addr[14:3]
  logic [63:0] mem [4096];
  logic [51:0] rd_log [64];
  logic [51:0] last_wr_addr;
  int          rd_cnt, wr_cnt;
  logic        tick, stall_en = 1'b0;

  assign mem_req_ready = !stall_en || tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 64'h0;
      mem[1*512+0] <= 64'h0000_0000_0000_2001;
      mem[1*512+1] <= 64'hFFFF_FFFF_FFFF_FFFE;
      mem[2*512+0] <= 64'h0000_0000_0000_3001;
      mem[2*512+5] <= 64'h8000_0000_0000_7FE0;
      mem[3*512+0] <= 64'h0000_0000_0000_4001;
      mem[3*512+7] <= 64'h7FFF_FFFF_FFFF_F0FE;
      mem[4*512+0] <= 64'h0000_0000_0012_3003;
      mem[4*512+1] <= 64'h8000_0000_0045_6021;
      mem[4*512+2] <= 64'h0000_0000_0078_9023;
      mem[4*512+3] <= 64'h0000_0000_000A_B063;
      mem[4*512+4] <= 64'h0000_0000_00DD_D0FE;
      mem[4*512+5] <= 64'h0000_0000_000C_D001;
      mem[4*512+6] <= 64'h0000_0000_000E_E001;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      rd_cnt <= 0;
      wr_cnt <= 0;
      tick   <= 1'b0;
      last_wr_addr <= '0;
    end else begin
      tick <= ~tick;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[14:3]] <= mem_req_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_req_addr;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[14:3]];
          rd_log[rd_cnt[5:0]] <= mem_req_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  typedef struct packed {
    logic [8:0]  i3, i2, i1, i0;
    logic        wr;
    logic        flt;
    logic [1:0]  lvl;
    logic [2:0]  nrd;
    logic        wb;
    logic [63:0] pte;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{9'd1, 9'd0, 9'd0, 9'd0, 1'b0, 1'b1, 2'd3, 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE},
    '{9'd0, 9'd5, 9'd0, 9'd0, 1'b1, 1'b1, 2'd2, 3'd2, 1'b0, 64'h8000_0000_0000_7FE0},
    '{9'd0, 9'd0, 9'd7, 9'd0, 1'b0, 1'b1, 2'd1, 3'd3, 1'b0, 64'h7FFF_FFFF_FFFF_F0FE},
    '{9'd0, 9'd0, 9'd0, 9'd4, 1'b1, 1'b1, 2'd0, 3'd4, 1'b0, 64'h0000_0000_00DD_D0FE},
    '{9'd0, 9'd0, 9'd0, 9'd0, 1'b0, 1'b0, 2'd0, 3'd4, 1'b1, 64'h0000_0000_0012_3023},
    '{9'd0, 9'd0, 9'd0, 9'd0, 1'b0, 1'b0, 2'd0, 3'd4, 1'b0, 64'h0000_0000_0012_3023},
    '{9'd0, 9'd0, 9'd0, 9'd1, 1'b0, 1'b0, 2'd0, 3'd4, 1'b0, 64'h8000_0000_0045_6021},
    '{9'd0, 9'd0, 9'd0, 9'd2, 1'b1, 1'b0, 2'd0, 3'd4, 1'b1, 64'h0000_0000_0078_9063},
    '{9'd0, 9'd0, 9'd0, 9'd3, 1'b1, 1'b0, 2'd0, 3'd4, 1'b0, 64'h0000_0000_000A_B063},
    '{9'd0, 9'd0, 9'd0, 9'd5, 1'b1, 1'b0, 2'd0, 3'd4, 1'b1, 64'h0000_0000_000C_D061},
    '{9'd0, 9'd0, 9'd0, 9'd0, 1'b1, 1'b0, 2'd0, 3'd4, 1'b1, 64'h0000_0000_0012_3063}
  };

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int rd0, wr0, n;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = {v.i3, v.i2, v.i1, v.i0};
    req_write = v.wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", 64'(busy), 64'd1);
    n = 0;
    while (!(walk_done || walk_fault) && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk("R7/R4 outcome fault", 64'(walk_fault), 64'(v.flt));
    chk("R7 outcome done", 64'(walk_done), 64'(!v.flt));
    chk("R4/R7 result entry", result_pte, v.pte);
    if (v.flt) chk("R4 fault level", 64'(fault_level), 64'(v.lvl));
    chk("R9 read count", 64'(rd_cnt - rd0), 64'(v.nrd));
    chk("R5/R6 write count", 64'(wr_cnt - wr0), 64'(v.wb));
    chk("R3 top-level address", 64'(rd_log[rd0[5:0]]), 64'({40'd1, v.i3, 3'b000}));
    if (v.nrd == 3'd4)
      chk("R3 leaf address", 64'(rd_log[(rd0 + 3) % 64]), 64'({40'd4, v.i0, 3'b000}));
    if (v.wb) chk("R5 write address", 64'(last_wr_addr), 64'({40'd4, v.i0, 3'b000}));
    @(negedge clk);
    chk("R2 idle after response", 64'(busy), 64'd0);
    chk("R7 pulse width", 64'(walk_done || walk_fault), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    vec_t sv;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R1 reset done", 64'(walk_done), 64'd0);
    chk("R1 reset fault", 64'(walk_fault), 64'd0);
    chk("R1 reset memory request", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", 64'(busy || mem_req_valid), 64'd0);

    for (int k = 0; k < NV; k++) run(VEC[k]);

    // R8: memory port stalls every other cycle
    stall_en = 1'b1;
    sv = '{9'd0, 9'd0, 9'd0, 9'd6, 1'b0, 1'b0, 2'd0, 3'd4, 1'b1, 64'h0000_0000_000E_E021};
    run(sv);
    sv = '{9'd0, 9'd0, 9'd0, 9'd6, 1'b1, 1'b0, 2'd0, 3'd4, 1'b1, 64'h0000_0000_000E_E061};
    run(sv);
    stall_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule